// File: doc/BRIEF.md
# Qualified Event Counter Pair

This block holds two independent 40-bit event counters that sit in a processor's performance monitoring unit. Each cycle the surrounding pipeline presents a small occurrence count for each of a set of event lanes. It presents two copies of these counts: one for activity caused by this agent and one for activity caused by other agents. It also presents the current privilege level. Each counter has its own control word. The control word picks an event lane and decides how that lane's count is qualified before anything is added.

Qualification combines several controls. A threshold compares the per-cycle count, either at-or-above the threshold or, when inverted, below it. A privilege filter has separate enables for supervisor and user levels. Edge mode counts only a false-to-true change of the qualified condition. When the threshold is zero, the block counts the raw, weighted value. A few event codes belong to one counter only. Software preloads and reads the counters and controls through a flat register port. A counter that wraps with its interrupt enabled raises a sticky flag and an interrupt line.

Top module: `evq_counter_pair`

## Requirements
- R1: After reset every register reads zero. The register map is: address 0 holds the global enable in bit 0, address 1 holds the overflow flags (bit n for counter n), addresses 2 and 3 hold the 32-bit controls of counters 0 and 1, and addresses 4 and 5 hold the 40-bit counts. Written controls and counts read back unchanged.
- R2: The control word is laid out as follows: code in [7:0], unit mask in [15:8], user enable in bit 16, supervisor enable in bit 17, edge in bit 18, interrupt enable in bit 19, invert in bit 20, threshold in [31:24]. With threshold 0 and edge clear, a counter adds the full qualified per-cycle count.
- R3: With a nonzero threshold and invert clear, a counter adds one in each cycle whose count is greater than or equal to the threshold, and adds nothing otherwise.
- R4: With a nonzero threshold and invert set, a counter adds one in each cycle whose count is below the threshold.
- R5: With edge set, a counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. With threshold 0, the condition is that the count is nonzero.
- R6: At privilege level 0 counting requires the supervisor enable. At levels 1 to 3 counting requires the user enable.
- R7: Code 14h counts only on counter 0, and codes 12h and 13h count only on counter 1. Codes at or above the lane count (32) count nothing on either counter.
- R8: Unit-mask bit 0 clear counts only this agent's lane value. Set, it counts the sum of this agent's and the other agents' values.
- R9: With the global enable clear, neither counter changes except by a software write.
- R10: A software write to a count takes effect on the next edge and overrides any increment in that same cycle.
- R11: A counter that carries out of bit 39 with its interrupt enabled sets its overflow flag, and the interrupt output equals the OR of the flags. Without the interrupt enable, the wrap sets nothing.
- R12: An overflow flag stays set until a write to address 1 with a 1 in its bit. A wrap in the same cycle as that write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 40 | Register write data |
| reg_rdata | output | 40 | Register read data, combinational from reg_addr |
| priv_lvl | input | 2 | Current privilege level, 0 is supervisor |
| ev_self | input | 128 | Per-lane counts from this agent, 4 bits per lane, lane k at [4k+3:4k] |
| ev_peer | input | 128 | Per-lane counts from other agents, same packing |
| irq | output | 1 | Overflow interrupt |

## Verification
Two pairs of functions can land in the same cycle. A software write to a count can coincide with a qualified increment. A status clear can coincide with a fresh wrap of a counter that has its interrupt enabled. The bench provokes the first by writing counts while heavy event traffic is applied. It provokes the second by preloading a counter one increment short of wrapping and issuing the status clear in exactly that increment's cycle. In both cases a behavioural model judges the result: the written value must win over the increment, and the new overflow must win over the clear.

// File: rtl/evq_pkg.sv
package evq_pkg;

  localparam logic [7:0] EV_MUL_CODE      = 8'h12;
  localparam logic [7:0] EV_DIV_CODE      = 8'h13;
  localparam logic [7:0] EV_DIVBUSY_CODE  = 8'h14;
  localparam int         DIVBUSY_OWNER    = 0;
  localparam int         MULDIV_OWNER     = 1;

  typedef struct packed {
    logic [7:0] thr;
    logic [2:0] rsvd;
    logic       inv;
    logic       irq_en;
    logic       edge_m;
    logic       os_en;
    logic       usr_en;
    logic [7:0] umask;
    logic [7:0] code;
  } ctrl_t;

  // Is this event code permitted on counter idx?
  function automatic logic code_ok(input int idx, input logic [7:0] code);
    if (code == EV_DIVBUSY_CODE && idx != DIVBUSY_OWNER) return 1'b0;
    if ((code == EV_MUL_CODE || code == EV_DIV_CODE) && idx != MULDIV_OWNER) return 1'b0;
    return 1'b1;
  endfunction

  // Per-cycle condition from count, threshold and invert.
  function automatic logic cond_eval(input logic [7:0] raw, input logic [7:0] thr,
                                     input logic inv);
    if (thr == 8'd0) return raw != 8'd0;
    if (inv) return raw < thr;
    return raw >= thr;
  endfunction

  function automatic logic priv_pass(input logic [1:0] priv, input logic os_en,
                                     input logic usr_en);
    return (priv == 2'd0) ? os_en : usr_en;
  endfunction

endpackage

// File: rtl/evq_lane_select.sv
module evq_lane_select #(
  parameter int NUM_LANES = 32,
  parameter int EVT_W     = 4,
  localparam int LW       = NUM_LANES * EVT_W,
  localparam int RAW_W    = EVT_W + 1
) (
  input  logic [LW-1:0]    ev_self,
  input  logic [LW-1:0]    ev_peer,
  input  logic [7:0]       code,
  input  logic             use_peer,
  output logic [RAW_W-1:0] raw,
  output logic             hit
);
  logic [EVT_W-1:0] sel_self;
  logic [EVT_W-1:0] sel_peer;

  always_comb begin
    sel_self = '0;
    sel_peer = '0;
    hit      = 1'b0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (code == 8'(k)) begin
        sel_self = ev_self[k*EVT_W +: EVT_W];
        sel_peer = ev_peer[k*EVT_W +: EVT_W];
        hit      = 1'b1;
      end
    end
  end

  assign raw = {1'b0, sel_self} + (use_peer ? {1'b0, sel_peer} : '0);

endmodule

// File: rtl/evq_qualifier.sv
module evq_qualifier
  import evq_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int RAW_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       code,
  input  logic             code_hit,
  input  logic [RAW_W-1:0] raw,
  input  logic [7:0]       thr,
  input  logic             inv,
  input  logic             edge_m,
  input  logic             os_en,
  input  logic             usr_en,
  input  logic [1:0]       priv,
  input  logic             glb_en,
  output logic             qual,
  output logic [RAW_W-1:0] inc
);
  logic level;
  logic allow;
  logic prev_q;

  always_comb begin
    level = cond_eval(8'(raw), thr, inv);
    allow = code_hit && code_ok(IDX, code) && priv_pass(priv, os_en, usr_en) && glb_en;
    qual  = level && allow;
    if (edge_m)
      inc = RAW_W'(qual && !prev_q);
    else if (thr == 8'd0)
      inc = qual ? raw : '0;
    else
      inc = RAW_W'(qual);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= qual;
  end

  assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_m && inc != '0) |-> inc == RAW_W'(1));

  assert_edge_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_m && inc != '0) |=> (!edge_m || inc == '0));

  assert_priv_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd0 && !os_en) |-> inc == '0);

  assert_divbusy_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (code == EV_DIVBUSY_CODE && IDX != DIVBUSY_OWNER) |-> inc == '0);

  assert_global_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> inc == '0);

endmodule

// File: rtl/evq_accum.sv
module evq_accum #(
  parameter int CNT_W = 40,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [INC_W-1:0] inc,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W:0] sum;

  assign sum  = {1'b0, cnt} + (CNT_W+1)'(inc);
  assign wrap = !wr && irq_en && sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (wr) cnt <= wdata;
    else         cnt <= sum[CNT_W-1:0];
  end

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cnt == $past(wdata));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && inc == '0) |=> $stable(cnt));

  assert_wrap_small_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt < CNT_W'($past(inc)));

endmodule

// File: rtl/evq_counter_pair.sv
module evq_counter_pair
  import evq_pkg::*;
#(
  parameter int NUM_CTR   = 2,
  parameter int CNT_W     = 40,
  parameter int NUM_LANES = 32,
  parameter int EVT_W     = 4,
  localparam int RAW_W    = EVT_W + 1,
  localparam int NREG     = 2 + 2 * NUM_CTR,
  localparam int AW       = $clog2(NREG),
  localparam int LW       = NUM_LANES * EVT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [1:0]       priv_lvl,
  input  logic [LW-1:0]    ev_self,
  input  logic [LW-1:0]    ev_peer,
  output logic             irq
);
  localparam logic [AW-1:0] A_GLB = AW'(0);
  localparam logic [AW-1:0] A_STS = AW'(1);
  localparam int            A_CFG = 2;
  localparam int            A_CNT = 2 + NUM_CTR;

  logic               glb_en;
  logic [NUM_CTR-1:0] ovf;
  logic               wr_glb;
  logic               wr_sts;
  logic               wrap    [NUM_CTR];
  logic               wr_cfg  [NUM_CTR];
  logic               wr_cnt  [NUM_CTR];
  ctrl_t              cfg     [NUM_CTR];
  logic [CNT_W-1:0]   cnt     [NUM_CTR];
  logic [RAW_W-1:0]   raw     [NUM_CTR];
  logic [RAW_W-1:0]   inc     [NUM_CTR];
  logic               hit     [NUM_CTR];
  logic               qual    [NUM_CTR];

  assign wr_glb = reg_wr && reg_addr == A_GLB;
  assign wr_sts = reg_wr && reg_addr == A_STS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      glb_en <= 1'b0;
    else if (wr_glb) glb_en <= reg_wdata[0];
  end

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      assign wr_cfg[i] = reg_wr && reg_addr == AW'(A_CFG + i);
      assign wr_cnt[i] = reg_wr && reg_addr == AW'(A_CNT + i);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg[i] <= '0;
        else if (wr_cfg[i]) cfg[i] <= ctrl_t'(reg_wdata[31:0]);
      end

      evq_lane_select #(.NUM_LANES(NUM_LANES), .EVT_W(EVT_W)) u_sel (
        .ev_self  (ev_self),
        .ev_peer  (ev_peer),
        .code     (cfg[i].code),
        .use_peer (cfg[i].umask[0]),
        .raw      (raw[i]),
        .hit      (hit[i])
      );

      evq_qualifier #(.IDX(i), .RAW_W(RAW_W)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (cfg[i].code),
        .code_hit (hit[i]),
        .raw      (raw[i]),
        .thr      (cfg[i].thr),
        .inv      (cfg[i].inv),
        .edge_m   (cfg[i].edge_m),
        .os_en    (cfg[i].os_en),
        .usr_en   (cfg[i].usr_en),
        .priv     (priv_lvl),
        .glb_en   (glb_en),
        .qual     (qual[i]),
        .inc      (inc[i])
      );

      evq_accum #(.CNT_W(CNT_W), .INC_W(RAW_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_cnt[i]),
        .wdata  (reg_wdata),
        .inc    (inc[i]),
        .irq_en (cfg[i].irq_en),
        .cnt    (cnt[i]),
        .wrap   (wrap[i])
      );

      assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[i] && !(wr_sts && reg_wdata[i])) |=> ovf[i]);

      assert_wrap_raises_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[i] |=> (ovf[i] && irq));

      assert_qual_needs_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[i] |-> !qual[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= '0;
    else begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (wrap[i])                      ovf[i] <= 1'b1;
        else if (wr_sts && reg_wdata[i]) ovf[i] <= 1'b0;
      end
    end
  end

  assign irq = |ovf;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_GLB) reg_rdata[0] = glb_en;
    if (reg_addr == A_STS) reg_rdata[NUM_CTR-1:0] = ovf;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr == AW'(A_CFG + i)) reg_rdata[31:0] = cfg[i];
      if (reg_addr == AW'(A_CNT + i)) reg_rdata = cnt[i];
    end
  end

endmodule

// File: tb/evq_counter_pair_test.sv
`timescale 1ns/10ps
module evq_counter_pair_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [39:0]  reg_wdata = '0;
  logic [39:0]  reg_rdata;
  logic [1:0]   priv_lvl = '0;
  logic [127:0] ev_self = '0;
  logic [127:0] ev_peer = '0;
  logic         irq;

  always #4 clk = ~clk;

  evq_counter_pair uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .priv_lvl(priv_lvl),
    .ev_self(ev_self), .ev_peer(ev_peer), .irq(irq)
  );

  localparam longint WRAPV = 64'd1 << 40;

  int     tests = 0;
  int     fails = 0;
  bit     done  = 0;
  string  tag   = "R1";
  int     sc [32];
  int     pc [32];
  int     prv = 0;
  longint m_cnt [2];
  bit [31:0] m_cfg [2];
  bit     m_en;
  bit [1:0] m_ovf;
  bit     m_prev [2];

  function automatic bit [31:0] mk(int code, int um, bit usr, bit os, bit edg,
                                   bit ien, bit inv, int thr);
    bit [31:0] w;
    w = '0;
    w[7:0] = 8'(code); w[15:8] = 8'(um); w[16] = usr; w[17] = os;
    w[18] = edg; w[19] = ien; w[20] = inv; w[31:24] = 8'(thr);
    return w;
  endfunction

  task automatic chk(string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    reg_addr = 3'd0; #0.4 chk("global", longint'(reg_rdata), longint'(m_en));
    reg_addr = 3'd1; #0.4 chk("status", longint'(reg_rdata), longint'(m_ovf));
    reg_addr = 3'd2; #0.4 chk("ctrl0", longint'(reg_rdata), longint'(m_cfg[0]));
    reg_addr = 3'd3; #0.4 chk("ctrl1", longint'(reg_rdata), longint'(m_cfg[1]));
    reg_addr = 3'd4; #0.4 chk("count0", longint'(reg_rdata), m_cnt[0]);
    reg_addr = 3'd5; #0.4 chk("count1", longint'(reg_rdata), m_cnt[1]);
    chk("irq", longint'(irq), longint'(m_ovf != 2'b00));
  endtask

  // One clock: drive at negedge, predict, check after the edge.
  task automatic cycle(bit w, int a, longint d);
    longint n_cnt [2];
    bit [1:0] setb;
    bit [1:0] clrb;
    bit n_prev [2];
    reg_wr = w; reg_addr = 3'(a); reg_wdata = 40'(d); priv_lvl = 2'(prv);
    for (int k = 0; k < 32; k++) begin
      ev_self[k*4 +: 4] = 4'(sc[k]);
      ev_peer[k*4 +: 4] = 4'(pc[k]);
    end
    setb = '0;
    for (int i = 0; i < 2; i++) begin
      int code, raw, thr, inc;
      bit lvl, ok, q;
      code = int'(m_cfg[i][7:0]);
      thr  = int'(m_cfg[i][31:24]);
      raw  = 0;
      if (code < 32) raw = sc[code] + (m_cfg[i][8] ? pc[code] : 0);
      if (thr == 0) lvl = raw != 0;
      else if (m_cfg[i][20]) lvl = raw < thr;
      else lvl = raw >= thr;
      ok = code < 32;
      if (code == 'h14 && i != 0) ok = 0;
      if ((code == 'h12 || code == 'h13) && i != 1) ok = 0;
      q = lvl && ok && m_en && ((prv == 0) ? m_cfg[i][17] : m_cfg[i][16]);
      if (m_cfg[i][18]) inc = (q && !m_prev[i]) ? 1 : 0;
      else if (thr == 0) inc = q ? raw : 0;
      else inc = q ? 1 : 0;
      n_prev[i] = q;
      if (w && a == 4 + i) n_cnt[i] = d;
      else begin
        n_cnt[i] = m_cnt[i] + inc;
        if (n_cnt[i] >= WRAPV) begin
          n_cnt[i] -= WRAPV;
          if (m_cfg[i][19]) setb[i] = 1;
        end
      end
    end
    clrb = (w && a == 1) ? 2'(d) : 2'b00;
    @(posedge clk);
    #1;
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = n_cnt[i];
      m_prev[i] = n_prev[i];
      if (w && a == 2 + i) m_cfg[i] = 32'(d);
    end
    if (w && a == 0) m_en = d[0];
    m_ovf = (m_ovf & ~clrb) | setb;
    reg_wr = 1'b0;
    compare_all();
    @(negedge clk);
  endtask

  task automatic set_all(int vs, int vp);
    for (int k = 0; k < 32; k++) begin sc[k] = vs; pc[k] = vp; end
  endtask

  task automatic set_pat(int c);
    for (int k = 0; k < 32; k++) begin
      sc[k] = (c * 5 + k * 3) % 16;
      pc[k] = (c * 7 + k) % 16;
    end
  endtask

  task automatic run_pat(int n, int base);
    for (int c = 0; c < n; c++) begin set_pat(base + c); cycle(0, 0, 0); end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_ovf = 0;
    for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_cfg[i] = 0; m_prev[i] = 0; end
    set_all(0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    tag = "R1"; compare_all();   // reset state
    @(negedge clk);

    // R1: preload and read back
    cycle(1, 4, 40'h12_3456_789A);
    cycle(1, 5, 40'hFF_0000_0001);
    cycle(1, 2, longint'(mk(5, 0, 1, 1, 0, 0, 0, 0)));
    cycle(1, 3, longint'(mk(6, 0, 1, 1, 0, 0, 0, 0)));
    run_pat(3, 0);                // global enable still clear: no counting (R9)
    cycle(1, 0, 1);

    tag = "R2"; run_pat(20, 3);
    tag = "R3";
    cycle(1, 2, longint'(mk(5, 0, 1, 1, 0, 0, 0, 3)));
    cycle(1, 3, longint'(mk(9, 0, 1, 1, 0, 0, 0, 12)));
    run_pat(20, 30);
    tag = "R4";
    cycle(1, 2, longint'(mk(5, 0, 1, 1, 0, 0, 1, 3)));
    cycle(1, 3, longint'(mk(9, 0, 1, 1, 0, 0, 1, 12)));
    run_pat(20, 60);
    tag = "R5";
    cycle(1, 2, longint'(mk(5, 0, 1, 1, 1, 0, 0, 2)));
    cycle(1, 3, longint'(mk(6, 0, 1, 1, 1, 0, 0, 0)));
    for (int c = 0; c < 24; c++) begin
      set_all(((c / 3) % 2 == 0) ? (c % 16) : 0, 0);
      cycle(0, 0, 0);
    end
    tag = "R6";
    cycle(1, 2, longint'(mk(5, 0, 0, 1, 0, 0, 0, 0)));
    cycle(1, 3, longint'(mk(6, 0, 1, 0, 0, 0, 0, 0)));
    for (int c = 0; c < 16; c++) begin prv = c % 4; set_pat(c + 90); cycle(0, 0, 0); end
    prv = 0;
    tag = "R7";
    cycle(1, 2, longint'(mk('h12, 0, 1, 1, 0, 0, 0, 0)));
    cycle(1, 3, longint'(mk('h14, 0, 1, 1, 0, 0, 0, 0)));
    set_all(7, 3); repeat (4) cycle(0, 0, 0);
    cycle(1, 2, longint'(mk('h14, 0, 1, 1, 0, 0, 0, 0)));
    cycle(1, 3, longint'(mk('h13, 0, 1, 1, 0, 0, 0, 0)));
    repeat (4) cycle(0, 0, 0);
    cycle(1, 2, longint'(mk('h13, 0, 1, 1, 0, 0, 0, 0)));
    cycle(1, 3, longint'(mk('h40, 0, 1, 1, 0, 0, 0, 0)));
    repeat (4) cycle(0, 0, 0);
    tag = "R8";
    cycle(1, 2, longint'(mk('h0A, 1, 1, 1, 0, 0, 0, 0)));
    cycle(1, 3, longint'(mk('h0A, 0, 1, 1, 0, 0, 0, 0)));
    run_pat(12, 120);
    cycle(1, 2, longint'(mk('h0B, 1, 1, 1, 0, 0, 0, 20)));
    run_pat(12, 140);
    tag = "R9";
    cycle(1, 0, 0);
    run_pat(8, 160);
    cycle(1, 0, 1);
    tag = "R10";
    set_all(15, 15);
    cycle(1, 4, 40'h00_0000_0100);
    cycle(1, 5, 40'h00_0000_0200);
    cycle(0, 0, 0);
    tag = "R11";
    cycle(1, 2, longint'(mk(5, 0, 1, 1, 0, 1, 0, 0)));
    cycle(1, 3, longint'(mk(6, 0, 1, 1, 0, 0, 0, 0)));
    set_all(10, 0);
    cycle(1, 4, WRAPV - 20);
    cycle(1, 5, WRAPV - 5);
    repeat (3) cycle(0, 0, 0);
    tag = "R12";
    repeat (2) cycle(0, 0, 0);
    cycle(1, 1, 1);               // clear, no wrap this cycle
    cycle(1, 4, WRAPV - 10);
    cycle(1, 1, 3);               // clear in the same cycle as a wrap
    cycle(0, 0, 0);
    cycle(1, 1, 1);
    repeat (2) cycle(0, 0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule